// File: doc/BRIEF.md
# RAM-Sourced Phase Path Selector

This block is the phase-generation datapath of a direct digital synthesizer. A phase accumulator adds a frequency step on every clock. A phase-offset adder then adds an offset into the top bits of the accumulator value, and the result is registered as the output phase word. The phase-to-amplitude stage downstream takes this word.

A stream of memory words can stand in for one of the two operands. A routing enable chooses whether the memory words take part at all. A routing destination chooses which operand they replace: the frequency step or the phase offset. The operand that the memory does not replace still comes from its own register. Both routing controls are sampled only on an update strobe, so the operand sources never change between strobes. A synchronous clear returns the accumulator to zero.

The memory playback sequencer that supplies the words is outside this block, and so is the amplitude conversion.

Top module: `ram_phase_path`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the output phase word is zero. After reset the memory routing is disabled and the accumulator holds zero.
- R2: The routing enable and destination inputs are sampled only on a clock edge where the update strobe is high. The new routing takes effect from the following edge onward.
- R3: With routing disabled, the accumulator adds the frequency word each cycle and the phase offset comes from the offset word.
- R4: With routing enabled and destination 0 (accumulator), the accumulator adds the full memory word each cycle and the phase offset comes from the offset word.
- R5: With routing enabled and destination 1 (offset adder), the accumulator adds the frequency word and the phase offset is memory word bits [31:18].
- R6: The accumulator is 32 bits wide and wraps modulo 2^32. The output phase word is also computed modulo 2^32.
- R7: When the clear input is high at an edge, the accumulator is zero after that edge, whatever the selected frequency step. Clear does not alter the routing.
- R8: The output phase word at an edge equals the accumulator value before that edge plus the selected 14-bit offset shifted left by 18. These are the operands selected by the routing in force before the edge.
- R9: A change on the routing inputs while the update strobe is low has no effect on the accumulator or the output phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_clr_i | input | 1 | Synchronous accumulator clear |
| route_upd_i | input | 1 | Strobe that loads the routing controls |
| ram_en_i | input | 1 | Routing enable for memory words |
| ram_dest_i | input | 1 | Memory destination: 0 accumulator, 1 offset adder |
| ftw_i | input | 32 | Frequency step register value |
| pow_i | input | 14 | Phase offset register value |
| ram_data_i | input | 32 | Memory word from the playback sequencer |
| phase_o | output | 32 | Registered output phase word |

## Verification
The assertions take for granted that every input is at a defined level on each clock edge after reset is released. They also assume that the frequency, offset and memory inputs are held for the whole clock period in which they are sampled. The bench drives all inputs only on the falling edge and keeps them fixed until the next falling edge. The update strobe and the clear are single-cycle levels that the stimulus raises at random, and sometimes together, so the assertions see every pairing of strobe, clear and routing.

// File: rtl/pps_pkg.sv
// Package: shared types for the RAM-sourced phase path.
// Assumes: one-bit destination encoding, 0 = accumulator, 1 = offset adder.
package pps_pkg;

    typedef enum logic {
        DEST_ACC = 1'b0,
        DEST_OFF = 1'b1
    } ram_dest_e;

    typedef struct packed {
        logic      en;
        ram_dest_e dest;
    } route_t;

endpackage

// File: rtl/pps_route_ctl.sv
// Module: pps_route_ctl
// Holds the memory routing controls. They change only on the update strobe,
// so the operand sources stay fixed between strobes.
// Assumes: rst_n is synchronous and active low.
module pps_route_ctl
    import pps_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   upd_i,
    input  logic   en_i,
    input  logic   dest_i,
    output route_t route_o
);

    route_t route_q;

    // Load routing on the strobe; reset leaves memory disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '{en: 1'b0, dest: DEST_ACC};
        end else if (upd_i) begin
            route_q <= '{en: en_i, dest: ram_dest_e'(dest_i)};
        end
    end

    assign route_o = route_q;

endmodule

// File: rtl/pps_operand_mux.sv
// Module: pps_operand_mux
// Picks the frequency step and the phase offset from either the registers
// or the memory word, according to the current routing.
// Assumes: when the memory word feeds the offset, its top OFF_W bits are used.
module pps_operand_mux
    import pps_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int OFF_W = 14,
    parameter int RAM_W = 32
) (
    input  route_t             route_i,
    input  logic [ACC_W-1:0]   ftw_i,
    input  logic [OFF_W-1:0]   pow_i,
    input  logic [RAM_W-1:0]   ram_i,
    output logic [ACC_W-1:0]   freq_o,
    output logic [OFF_W-1:0]   off_o
);

    localparam int RAM_TOP = RAM_W - 1;

    logic [ACC_W-1:0] ram_as_freq;
    logic [OFF_W-1:0] ram_as_off;
    logic             ram_to_acc;
    logic             ram_to_off;

    // Fit the memory word to the accumulator width.
    generate
        if (RAM_W >= ACC_W) begin : g_ram_wide
            assign ram_as_freq = ram_i[ACC_W-1:0];
        end else begin : g_ram_narrow
            assign ram_as_freq = {{(ACC_W-RAM_W){1'b0}}, ram_i};
        end
    endgenerate

    assign ram_as_off = ram_i[RAM_TOP -: OFF_W];
    assign ram_to_acc = route_i.en && (route_i.dest == DEST_ACC);
    assign ram_to_off = route_i.en && (route_i.dest == DEST_OFF);

    // Operand selection: memory replaces one input, the register feeds the other.
    always_comb begin
        freq_o = ram_to_acc ? ram_as_freq : ftw_i;
        off_o  = ram_to_off ? ram_as_off  : pow_i;
    end

endmodule

// File: rtl/pps_phase_acc.sv
// Module: pps_phase_acc
// Phase accumulator: adds the step each clock and wraps at 2^ACC_W.
// Assumes: the clear has priority over the addition.
module pps_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [ACC_W-1:0] step_i,
    output logic [ACC_W-1:0] acc_o
);

    logic [ACC_W-1:0] acc_q;

    // Accumulate with modular wrap, or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + step_i;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/pps_offset_add.sv
// Module: pps_offset_add
// Adds the phase offset into the top OFF_W bits of the accumulator value
// and registers the sum as the output phase word.
// Assumes: OFF_W <= ACC_W.
module pps_offset_add #(
    parameter int ACC_W = 32,
    parameter int OFF_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [ACC_W-1:0] phase_o
);

    localparam int SHIFT = ACC_W - OFF_W;

    logic [ACC_W-1:0] off_aligned;
    logic [ACC_W-1:0] phase_q;

    // Align the offset to the top of the word.
    generate
        if (SHIFT > 0) begin : g_shift
            assign off_aligned = {off_i, {SHIFT{1'b0}}};
        end else begin : g_full
            assign off_aligned = off_i;
        end
    endgenerate

    // Register the offset sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= acc_i + off_aligned;
        end
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/ram_phase_path.sv
// Module: ram_phase_path (top)
// DDS phase datapath in which a memory word stream can replace either the
// frequency step or the phase offset, chosen by latched routing controls.
// Assumes: all inputs settle within one clock; routing loads on route_upd_i.
module ram_phase_path
    import pps_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int OFF_W = 14,
    parameter int RAM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_clr_i,
    input  logic             route_upd_i,
    input  logic             ram_en_i,
    input  logic             ram_dest_i,
    input  logic [ACC_W-1:0] ftw_i,
    input  logic [OFF_W-1:0] pow_i,
    input  logic [RAM_W-1:0] ram_data_i,
    output logic [ACC_W-1:0] phase_o
);

    route_t           route;
    logic [ACC_W-1:0] freq_op;
    logic [OFF_W-1:0] off_op;
    logic [ACC_W-1:0] acc_val;

    pps_route_ctl u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (route_upd_i),
        .en_i    (ram_en_i),
        .dest_i  (ram_dest_i),
        .route_o (route)
    );

    pps_operand_mux #(
        .ACC_W (ACC_W),
        .OFF_W (OFF_W),
        .RAM_W (RAM_W)
    ) u_mux (
        .route_i (route),
        .ftw_i   (ftw_i),
        .pow_i   (pow_i),
        .ram_i   (ram_data_i),
        .freq_o  (freq_op),
        .off_o   (off_op)
    );

    pps_phase_acc #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (acc_clr_i),
        .step_i (freq_op),
        .acc_o  (acc_val)
    );

    pps_offset_add #(
        .ACC_W (ACC_W),
        .OFF_W (OFF_W)
    ) u_off (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_i   (acc_val),
        .off_i   (off_op),
        .phase_o (phase_o)
    );

endmodule

// File: rtl/pps_checker.sv
// Module: pps_checker
// Temporal checks on the phase path, bound to the top module.
// Assumes: inputs are defined at every clock edge after reset.
module pps_checker #(
    parameter int ACC_W = 32,
    parameter int OFF_W = 14,
    parameter int RAM_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_clr_i,
    input logic             route_upd_i,
    input logic             ram_en_i,
    input logic             ram_dest_i,
    input logic [ACC_W-1:0] ftw_i,
    input logic [OFF_W-1:0] pow_i,
    input logic [RAM_W-1:0] ram_data_i,
    input logic [1:0]       route_bits,
    input logic [ACC_W-1:0] freq_op,
    input logic [OFF_W-1:0] off_op,
    input logic [ACC_W-1:0] acc_val,
    input logic [ACC_W-1:0] phase_o
);

    localparam int SHIFT = ACC_W - OFF_W;

    // R2: routing loads the sampled inputs on the strobe.
    a_r2_route_load: assert property (@(posedge clk) disable iff (!rst_n)
        route_upd_i |=> route_bits == {$past(ram_en_i), $past(ram_dest_i)});

    // R9: routing holds without the strobe.
    a_r9_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !route_upd_i |=> $stable(route_bits));

    // R3: disabled routing uses both registers.
    a_r3_regs_direct: assert property (@(posedge clk) disable iff (!rst_n)
        !route_bits[1] |-> (freq_op == ftw_i) && (off_op == pow_i));

    // R4: memory to accumulator keeps the offset register.
    a_r4_ram_to_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (route_bits == 2'b10) |-> (freq_op == ram_data_i[ACC_W-1:0]) && (off_op == pow_i));

    // R5: memory to offset keeps the frequency register.
    a_r5_ram_to_off: assert property (@(posedge clk) disable iff (!rst_n)
        (route_bits == 2'b11) |-> (freq_op == ftw_i) && (off_op == ram_data_i[RAM_W-1 -: OFF_W]));

    // R6: accumulator steps by the selected operand, modulo 2^ACC_W.
    a_r6_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_clr_i |=> acc_val == ACC_W'($past(acc_val) + $past(freq_op)));

    // R7: clear forces zero.
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr_i |=> acc_val == '0);

    // R8: output is previous accumulator plus aligned offset.
    a_r8_phase_sum: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase_o == ACC_W'($past(acc_val) + ($past({{SHIFT{1'b0}}, off_op}) << SHIFT)));

endmodule

bind ram_phase_path pps_checker #(
    .ACC_W (ACC_W),
    .OFF_W (OFF_W),
    .RAM_W (RAM_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_clr_i   (acc_clr_i),
    .route_upd_i (route_upd_i),
    .ram_en_i    (ram_en_i),
    .ram_dest_i  (ram_dest_i),
    .ftw_i       (ftw_i),
    .pow_i       (pow_i),
    .ram_data_i  (ram_data_i),
    .route_bits  (route),
    .freq_op     (freq_op),
    .off_op      (off_op),
    .acc_val     (acc_val),
    .phase_o     (phase_o)
);

// File: tb/ram_phase_path_tb_top.sv
// Bench: reference model in functions, random stimulus plus directed corners.
module ram_phase_path_tb_top;

    localparam int ACC_W = 32;
    localparam int OFF_W = 14;
    localparam int RAM_W = 32;
    localparam int SH    = ACC_W - OFF_W;
    localparam int WATCHDOG = 100000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             acc_clr_i;
    logic             route_upd_i;
    logic             ram_en_i;
    logic             ram_dest_i;
    logic [ACC_W-1:0] ftw_i;
    logic [OFF_W-1:0] pow_i;
    logic [RAM_W-1:0] ram_data_i;
    logic [ACC_W-1:0] phase_o;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state
    logic [ACC_W-1:0] m_acc;
    logic [ACC_W-1:0] m_phase;
    logic             m_en;
    logic             m_dest;

    always #10 clk = ~clk;

    ram_phase_path #(.ACC_W(ACC_W), .OFF_W(OFF_W), .RAM_W(RAM_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_clr_i   (acc_clr_i),
        .route_upd_i (route_upd_i),
        .ram_en_i    (ram_en_i),
        .ram_dest_i  (ram_dest_i),
        .ftw_i       (ftw_i),
        .pow_i       (pow_i),
        .ram_data_i  (ram_data_i),
        .phase_o     (phase_o)
    );

    function automatic logic [ACC_W-1:0] ref_step(logic en, logic dest,
            logic [ACC_W-1:0] ftw, logic [RAM_W-1:0] ram);
        return (en && !dest) ? ram : ftw;
    endfunction

    function automatic logic [OFF_W-1:0] ref_off(logic en, logic dest,
            logic [OFF_W-1:0] pw, logic [RAM_W-1:0] ram);
        return (en && dest) ? ram[31:18] : pw;
    endfunction

    task automatic check(string tag);
        n_cmp++;
        if (phase_o !== m_phase) begin
            n_bad++;
            $display("FAIL %s: phase_o=%h expected=%h", tag, phase_o, m_phase);
        end
    endtask

    // Drive one cycle at the falling edge, advance the model, compare.
    task automatic step(logic [ACC_W-1:0] ftw, logic [OFF_W-1:0] pw,
            logic [RAM_W-1:0] ram, logic en, logic dest, logic upd, logic clr,
            string extra);
        string tag;
        tag = !m_en ? "R3" : (m_dest ? "R5" : "R4");
        ftw_i = ftw; pow_i = pw; ram_data_i = ram;
        ram_en_i = en; ram_dest_i = dest; route_upd_i = upd; acc_clr_i = clr;
        @(posedge clk);
        m_phase = m_acc + ({{SH{1'b0}}, ref_off(m_en, m_dest, pw, ram)} << SH);
        m_acc   = clr ? '0 : m_acc + ref_step(m_en, m_dest, ftw, ram);
        if (upd) begin
            m_en = en; m_dest = dest;
        end
        @(negedge clk);
        check({tag, "/R8", extra});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; acc_clr_i = 0; route_upd_i = 0; ram_en_i = 1; ram_dest_i = 1;
        ftw_i = 32'h1234_5678; pow_i = 14'h3FFF; ram_data_i = 32'hFFFF_FFFF;
        m_acc = '0; m_phase = '0; m_en = 0; m_dest = 0;
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        // R1: first cycle after reset, memory disabled, accumulator zero
        step(32'h0000_0100, 14'h0001, 32'hDEAD_BEEF, 1, 1, 0, 0, " R1 post-reset");
        step(32'h0000_0100, 14'h0001, 32'hDEAD_BEEF, 1, 0, 0, 0, " R1 R9");
        // R2: load destination accumulator
        step(32'h0000_0010, 14'h0002, 32'h0001_0000, 1, 0, 1, 0, " R2 load");
        step(32'h0000_0010, 14'h0002, 32'h0001_0000, 0, 1, 0, 0, " R4 R9");
        step(32'h0000_0010, 14'h0002, 32'h0003_0000, 0, 0, 0, 0, " R4");
        // R5: route to offset adder
        step(32'h0000_0020, 14'h0005, 32'hABCD_0000, 1, 1, 1, 0, " R2 load");
        step(32'h0000_0020, 14'h0005, 32'hFFFC_0000, 0, 0, 0, 0, " R5");
        step(32'h0000_0020, 14'h0005, 32'h0004_0000, 0, 0, 0, 0, " R5 low bit");
        // R7: clear together with strobe to disabled
        step(32'hFFFF_FFFF, 14'h0000, 32'h0, 0, 0, 1, 1, " R7 clr");
        step(32'hC000_0000, 14'h0000, 32'h0, 0, 0, 0, 0, " R7 after");
        // R6: wrap
        step(32'hC000_0000, 14'h3FFF, 32'h0, 0, 0, 0, 0, " R6 wrap");
        step(32'hC000_0000, 14'h3FFF, 32'h0, 0, 0, 0, 0, " R6 wrap");
        step(32'h0, 14'h3FFF, 32'h0, 0, 0, 0, 0, " R6 phase wrap");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            step($urandom, 14'($urandom), $urandom, 1'($urandom), 1'($urandom),
                 ($urandom % 8) == 0, ($urandom % 32) == 0, " rand R2 R6 R7 R9");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: cycles=%0d expected<%0d", WATCHDOG, WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule